// File: doc/BRIEF.md
# Variable-Rate Time-Slot PCM Port

This block connects a word-parallel core to a serial PCM highway running in variable-rate mode. Each direction has its own bit clock and its own level-sensitive slot enable. The block oversamples the bit clocks, the enables and the receive data with the system clock. While the transmit enable is high, an 8-bit word leaves on successive rising bit-clock edges, sign bit (MSB) first. The same word goes out again in every further slot for as long as the enable stays high. While the receive enable is high, bits are taken on falling bit-clock edges, MSB first, and every complete group of 8 is handed to the core.

The transmit word comes in over a valid/ready handshake into a single staging register. `tx_word_ready` is high while that register is empty. A word is accepted on a clock where `tx_word_valid` and `tx_word_ready` are both high. Offering a word while `tx_word_ready` is low has no effect, and the offer must be held or repeated. The staged word moves into the shifter only at the rising edge of the transmit enable, and that empties the staging register. The receive side has no back-pressure: `rx_word_valid` is a one-cycle pulse and the word must be taken in that cycle. The serial output is a data bit plus a drive enable, for an external tri-state buffer. No signaling, companding or analog function is present.

Top module: `vr_pcm_port`

## Requirements
- R1: After reset, `tx_sd_oe` is 0, `rx_word_valid` is 0 and `tx_word_ready` is 1. The transmit word register holds 8'h00.
- R2: While the transmit enable is high, each rising edge of `tx_bclk` drives the next bit of the current word on `tx_sd`, MSB first. `tx_sd_oe` is 1 from the first such edge. Each bit appears 3 system clocks after the edge reaches the pin.
- R3: After 8 bits in one enable window, the bit position wraps and the same word is sent again for as long as the enable stays high.
- R4: Once the synchronized transmit enable is low, `tx_sd_oe` is 0, which means the line is in high impedance.
- R5: A handshake (valid and ready both high) stores the word and drops `tx_word_ready` until the next rising edge of the transmit enable. A word offered while ready is low is ignored.
- R6: If no word is staged at a rising edge of the transmit enable, the previous word is sent again.
- R7: While the receive enable is high, each falling edge of `rx_bclk` shifts in `rx_sd`, MSB first. After the 8th bit, `rx_word_valid` pulses for one system clock with the word on `rx_word_data`.
- R8: Further groups of 8 falling edges in the same enable window each produce another word.
- R9: If the receive enable falls before 8 bits have arrived, the partial word is dropped and no pulse is issued.
- R10: A rising edge of either enable restarts that direction at the MSB.
- R11: Transmit and receive run at unrelated bit-clock rates at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all highway pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_slot_en | input | 1 | Transmit slot enable, level sensitive |
| tx_word_data | input | WORD_W | Word to transmit |
| tx_word_valid | input | 1 | Transmit word offered |
| tx_word_ready | output | 1 | Staging register empty |
| tx_sd | output | 1 | Serial transmit data |
| tx_sd_oe | output | 1 | Drive enable for the serial output |
| rx_bclk | input | 1 | Receive bit clock |
| rx_slot_en | input | 1 | Receive slot enable, level sensitive |
| rx_sd | input | 1 | Serial receive data |
| rx_word_data | output | WORD_W | Last complete received word |
| rx_word_valid | output | 1 | One-cycle pulse for a new received word |

## Verification
A bit counter that slips or fails to reset at an enable edge shows up on `tx_sd` in the very next bit, because the output reorders or starts mid-word. The same fault on the receive side shows up as a mistimed or corrupted `rx_word_valid` within one word time. A staging flag stuck in the wrong state is visible on `tx_word_ready` in the next cycle, and as a wrong word at the start of the next transmit window. A drive enable that stays on after the enable falls is seen 3 clocks after the pin drops. The bench model follows the pin-level rules one cycle at a time, so any such fault is reported in the cycle where it first appears.

// File: rtl/vr_pcm_pkg.sv
package vr_pcm_pkg;
  localparam int unsigned PCM_WORD_W      = 8;
  localparam int unsigned PCM_SYNC_STAGES = 2;

  // Level and single-cycle edge strobes of one oversampled pin
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pcm_edge_t;
endpackage

// File: rtl/vr_pcm_sync.sv
module vr_pcm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/vr_pcm_edge.sv
module vr_pcm_edge
  import vr_pcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      d,
  output pcm_edge_t e
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= d;
  end

  assign e.level = d;
  assign e.rise  = d & ~prev_q;
  assign e.fall  = ~d & prev_q;
endmodule

// File: rtl/vr_pcm_tx.sv
module vr_pcm_tx
  import vr_pcm_pkg::*;
#(
  parameter int unsigned WORD_W = PCM_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcm_edge_t         bclk_e,
  input  pcm_edge_t         en_e,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              sd,
  output logic              sd_oe
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              pend_q;
  logic [WORD_W-1:0] stage_q, cur_q, word_now;
  logic [CNT_W-1:0]  cnt_q, cnt_now, cnt_inc;
  logic              sd_q, oe_q, hs, drive;

  assign hs       = word_valid & ~pend_q;
  assign drive    = bclk_e.rise & en_e.level;
  assign word_now = en_e.rise ? (pend_q ? stage_q : cur_q) : cur_q;
  assign cnt_now  = en_e.rise ? '0 : cnt_q;
  assign cnt_inc  = (cnt_now == LAST) ? '0 : cnt_now + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stage_q <= '0;
      cur_q   <= '0;
    end else begin
      if (en_e.rise) begin
        cur_q  <= word_now;
        pend_q <= 1'b0;
      end
      if (hs) begin
        stage_q <= word_data;
        pend_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sd_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!en_e.level) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (drive) begin
      cnt_q <= cnt_inc;
      sd_q  <= word_now[LAST - cnt_now];
      oe_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_now;
    end
  end

  assign word_ready = ~pend_q;
  assign sd         = sd_q;
  assign sd_oe      = oe_q;

  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> $past(en_e.level)); // R4
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !word_ready); // R5
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_e.level && !bclk_e.rise && !en_e.rise) |=> $stable(cnt_q)); // R2
  AST_WORD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_e.rise |=> $stable(cur_q)); // R3
endmodule

// File: rtl/vr_pcm_rx.sv
module vr_pcm_rx
  import vr_pcm_pkg::*;
#(
  parameter int unsigned WORD_W = PCM_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcm_edge_t         bclk_e,
  input  pcm_edge_t         en_e,
  input  logic              sd,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_now;
  logic [WORD_W-1:0] sh_q, sh_next, word_q;
  logic              valid_q, cap;

  assign cnt_now = en_e.rise ? '0 : cnt_q;
  assign cap     = bclk_e.fall & en_e.level;
  assign sh_next = {sh_q[WORD_W-2:0], sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_e.level) begin
        cnt_q <= '0;
      end else if (cap) begin
        sh_q <= sh_next;
        if (cnt_now == LAST) begin
          word_q  <= sh_next;
          valid_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_now + CNT_W'(1);
        end
      end else begin
        cnt_q <= cnt_now;
      end
    end
  end

  assign word_data  = word_q;
  assign word_valid = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R7
  AST_VALID_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(en_e.level)); // R9
endmodule

// File: rtl/vr_pcm_port.sv
module vr_pcm_port
  import vr_pcm_pkg::*;
#(
  parameter int unsigned WORD_W      = PCM_WORD_W,
  parameter int unsigned SYNC_STAGES = PCM_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bclk,
  input  logic              tx_slot_en,
  input  logic [WORD_W-1:0] tx_word_data,
  input  logic              tx_word_valid,
  output logic              tx_word_ready,
  output logic              tx_sd,
  output logic              tx_sd_oe,
  input  logic              rx_bclk,
  input  logic              rx_slot_en,
  input  logic              rx_sd,
  output logic [WORD_W-1:0] rx_word_data,
  output logic              rx_word_valid
);
  logic [1:0] tx_pins_s;
  logic [2:0] rx_pins_s;
  pcm_edge_t  tx_bclk_e, tx_en_e, rx_bclk_e, rx_en_e;

  vr_pcm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .d({tx_bclk, tx_slot_en}), .q(tx_pins_s));
  vr_pcm_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d({rx_bclk, rx_slot_en, rx_sd}), .q(rx_pins_s));

  vr_pcm_edge u_tx_bclk_edge (.clk(clk), .rst_n(rst_n), .d(tx_pins_s[1]), .e(tx_bclk_e));
  vr_pcm_edge u_tx_en_edge   (.clk(clk), .rst_n(rst_n), .d(tx_pins_s[0]), .e(tx_en_e));
  vr_pcm_edge u_rx_bclk_edge (.clk(clk), .rst_n(rst_n), .d(rx_pins_s[2]), .e(rx_bclk_e));
  vr_pcm_edge u_rx_en_edge   (.clk(clk), .rst_n(rst_n), .d(rx_pins_s[1]), .e(rx_en_e));

  vr_pcm_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bclk_e(tx_bclk_e), .en_e(tx_en_e),
    .word_data(tx_word_data), .word_valid(tx_word_valid), .word_ready(tx_word_ready),
    .sd(tx_sd), .sd_oe(tx_sd_oe));

  vr_pcm_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_e(rx_bclk_e), .en_e(rx_en_e), .sd(rx_pins_s[0]),
    .word_data(rx_word_data), .word_valid(rx_word_valid));
endmodule

// File: tb/test_vr_pcm_port.sv
`timescale 1ns/1ps
module test_vr_pcm_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bclk = 0, tx_slot_en = 0, tx_word_valid = 0;
  logic [7:0] tx_word_data = 8'h00;
  logic tx_word_ready, tx_sd, tx_sd_oe;
  logic rx_bclk = 0, rx_slot_en = 0, rx_sd = 0;
  logic [7:0] rx_word_data;
  logic rx_word_valid;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vr_pcm_port i_vr_pcm_port (
    .clk(clk), .rst_n(rst_n), .tx_bclk(tx_bclk), .tx_slot_en(tx_slot_en),
    .tx_word_data(tx_word_data), .tx_word_valid(tx_word_valid), .tx_word_ready(tx_word_ready),
    .tx_sd(tx_sd), .tx_sd_oe(tx_sd_oe), .rx_bclk(rx_bclk), .rx_slot_en(rx_slot_en),
    .rx_sd(rx_sd), .rx_word_data(rx_word_data), .rx_word_valid(rx_word_valid));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: pins seen two system clocks late, edges judged against one more
  logic [4:0] hist [4];
  logic [7:0] m_stage, m_cur, m_sh, m_word;
  logic m_pend, m_sd, m_oe, m_val;
  int m_tcnt, m_rcnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = '0;
      m_stage = 0; m_cur = 0; m_sh = 0; m_word = 0;
      m_pend = 0; m_sd = 0; m_oe = 0; m_val = 0; m_tcnt = 0; m_rcnt = 0;
    end else begin
      logic hs;
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0];
      hist[0] = {tx_bclk, tx_slot_en, rx_bclk, rx_slot_en, rx_sd};
      hs = tx_word_valid && !m_pend;
      if (hist[2][3] && !hist[3][3]) begin
        if (m_pend) m_cur = m_stage;
        m_pend = 0; m_tcnt = 0;
      end
      if (hs) begin m_stage = tx_word_data; m_pend = 1; end
      if (!hist[2][3]) begin
        m_oe = 0; m_tcnt = 0;
      end else if (hist[2][4] && !hist[3][4]) begin
        m_sd = m_cur[7 - m_tcnt]; m_oe = 1; m_tcnt = (m_tcnt + 1) % 8;
      end
      m_val = 0;
      if (hist[2][1] && !hist[3][1]) m_rcnt = 0;
      if (!hist[2][1]) begin
        m_rcnt = 0;
      end else if (!hist[2][2] && hist[3][2]) begin
        m_sh = {m_sh[6:0], hist[2][0]};
        m_rcnt++;
        if (m_rcnt == 8) begin m_val = 1; m_word = m_sh; m_rcnt = 0; end
      end
    end
  end

  logic [7:0] rx_exp [$];

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 model drive enable", tx_sd_oe, m_oe);
      if (m_oe) check("R2 model serial bit", tx_sd, m_sd);
      check("R5 model ready", tx_word_ready, !m_pend);
      check("R7 model valid", rx_word_valid, m_val);
      if (rx_word_valid) begin
        if (rx_exp.size() == 0) check("R9 unexpected word", rx_word_data, 32'hFFFF_FFFF);
        else check("R7 received word", rx_word_data, rx_exp.pop_front());
      end
    end
  end

  task automatic push_word(input logic [7:0] w);
    check("R5 ready before push", tx_word_ready, 1);
    tx_word_valid = 1; tx_word_data = w;
    @(negedge clk);
    tx_word_valid = 0;
    check("R5 ready low after push", tx_word_ready, 0);
  endtask

  task automatic tx_bit(output logic b);
    tx_bclk = 1;
    repeat (3) @(negedge clk);
    b = tx_sd;
    check("R2 drive on during slot", tx_sd_oe, 1);
    @(negedge clk);
    tx_bclk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] exp, input int nwords, input int partial);
    logic [7:0] got;
    logic b;
    tx_slot_en = 1;
    repeat (4) @(negedge clk);
    for (int w = 0; w < nwords; w++) begin
      for (int i = 0; i < 8; i++) begin tx_bit(b); got[7 - i] = b; end
      check(w == 0 ? "R2 first word" : "R3 repeated word", got, exp);
    end
    for (int i = 0; i < partial; i++) begin
      tx_bit(b);
      check("R10 partial bit", b, exp[7 - i]);
    end
    tx_slot_en = 0;
    repeat (4) @(negedge clk);
    check("R4 released after enable low", tx_sd_oe, 0);
  endtask

  task automatic rx_frame(input logic [7:0] words [$], input logic [7:0] tail, input int partial);
    rx_slot_en = 1;
    repeat (4) @(negedge clk);
    foreach (words[k]) begin
      rx_exp.push_back(words[k]);
      for (int i = 0; i < 8; i++) begin
        rx_bclk = 1; rx_sd = words[k][7 - i];
        repeat (5) @(negedge clk);
        rx_bclk = 0;
        repeat (5) @(negedge clk);
      end
    end
    for (int i = 0; i < partial; i++) begin
      rx_bclk = 1; rx_sd = tail[7 - i];
      repeat (5) @(negedge clk);
      rx_bclk = 0;
      repeat (5) @(negedge clk);
    end
    rx_slot_en = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset drive enable", tx_sd_oe, 0);
    check("R1 reset valid", rx_word_valid, 0);
    check("R1 reset ready", tx_word_ready, 1);

    // R1: no word staged yet, the reset word goes out
    tx_frame(8'h00, 1, 0);

    // R5: a word offered while not ready is ignored; R2/R3 repeat in one window
    push_word(8'hA5);
    tx_word_valid = 1; tx_word_data = 8'h3C;
    repeat (3) @(negedge clk);
    tx_word_valid = 0;
    check("R5 still not ready", tx_word_ready, 0);
    tx_frame(8'hA5, 2, 0);
    check("R5 ready after enable edge", tx_word_ready, 1);

    // R6: nothing staged, previous word again
    tx_frame(8'hA5, 1, 0);

    // R10: a partial window, then the next window restarts at the MSB
    push_word(8'h5A);
    tx_frame(8'h5A, 0, 3);
    tx_frame(8'h5A, 1, 0);

    // R11/R8: both directions together at different bit rates
    push_word(8'hC3);
    fork
      tx_frame(8'hC3, 3, 0);
      rx_frame('{8'h96, 8'h0F, 8'hE1}, 8'h00, 0);
    join

    // R9: partial receive dropped, then R10 fresh alignment on the next window
    rx_frame('{8'h81}, 8'hFF, 5);
    check("R9 partial word dropped", rx_exp.size(), 0);
    rx_frame('{8'h7E}, 8'h00, 0);
    repeat (10) @(negedge clk);
    check("R8 all words delivered", rx_exp.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule